// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block walks a freshly reset DDR1 or DDR2 memory device through its initialisation steps. A strap input selects the memory type. The start pulse launches one of two fixed step programs. Each step does one of four things: it loads the mode-register value bus, loads the extended-mode value bus, fires a single command strobe, or loads the refresh-control and DQS tap outputs. A wait follows every step, and its length is set by a parameter in clock cycles.

The DDR2 program is longer than the DDR1 program. It opens with two short-spaced extended-mode-2/3 updates, which stand for the early configuration phase. It also adds a second pair of extended-mode-2/3 updates, and it ends its command phase with an on-die-calibration enable/disable pair of extended-mode writes. When the last step completes, the block holds the refresh control word and the tap settings, and it raises done. Done stays high until the next reset.

Top module: `dram_bringup_seq`

## Requirements
- R1: After reset all outputs are zero and done is low. Without a start pulse the block issues no strobe and changes no output.
- R2: The `cmd_pulse` bits are one-hot, with bit0 = mode-register update, bit1 = extended-mode update, bit2 = auto-refresh, bit3 = precharge-all, bit4 = extended-mode-2 update and bit5 = extended-mode-3 update. Each strobe lasts exactly one cycle.
- R3: With `strap_ddr1`=1 the steps are:
  - precharge-all;
  - ext value 0x000;
  - ext update;
  - mode 0x133;
  - mode update;
  - precharge-all;
  - auto-refresh;
  - auto-refresh;
  - mode 0x033;
  - mode update;
  - refresh load;
  - tap load.
- R4: With `strap_ddr1`=0 the steps are:
  - ext2 update;
  - ext3 update;
  - precharge-all;
  - ext2 update;
  - ext3 update;
  - ext value 0x402;
  - ext update;
  - mode 0x143;
  - mode update;
  - precharge-all;
  - auto-refresh;
  - auto-refresh;
  - mode 0x043;
  - mode update;
  - ext value 0x782;
  - ext update;
  - ext value 0x402;
  - ext update;
  - refresh load;
  - tap load.
- R5: The first step takes effect one cycle after the clock edge that accepts start. Each later step takes effect LONG_WAIT+1 cycles after the previous one, except that the two steps after the first two DDR2 steps follow SHORT_WAIT+1 cycles later. No output changes between steps.
- R6: `mode_val` and `emode_val` change only on their own load steps, so they are stable in the cycle before and during every strobe.
- R7: The refresh load sets `refresh_ctl` to enable bit 14 plus a 10-bit period of 312 in bits 9:0, which gives 0x4138.
- R8: The tap load sets both `dqs_tap0` and `dqs_tap1` to 0x20 for DDR1 or 0x10 for DDR2. Done rises in that same cycle and stays high until reset.
- R9: The strap is captured when start is accepted. Changes to the strap during the sequence have no effect.
- R10: A start pulse during the sequence or after done has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches the sequence when idle |
| strap_ddr1 | input | 1 | Memory type: 1 = DDR1, 0 = DDR2 |
| cmd_pulse | output | 6 | One-hot command strobes |
| mode_val | output | MRW (13) | Mode-register value bus |
| emode_val | output | MRW (13) | Extended-mode value bus |
| refresh_ctl | output | 15 | Refresh control word |
| dqs_tap0 | output | TAPW (6) | DQS lane 0 delay tap |
| dqs_tap1 | output | TAPW (6) | DQS lane 1 delay tap |
| done | output | 1 | Sequence complete, sticky |

## Verification
The hardest step to observe is the DDR1 extended-mode load of zero. The bus already holds zero at that point, so the step cannot be seen as a change on the outputs. The bench therefore does not watch for changes. It predicts the exact cycle of every step from the wait parameters and compares the whole output state in every cycle, which also catches steps that drift by a cycle. Throughout each run the bench drives random start pulses and strap flips at random times, including inside the long waits and after done, so that the captured strap and the lockout of start are both tested.

// File: rtl/dram_bringup_seq.sv
module dram_bringup_seq #(
  parameter int SHORT_WAIT = 10,
  parameter int LONG_WAIT  = 100,
  parameter int MRW        = 13,
  parameter int TAPW       = 6,
  parameter int REF_PERIOD = 312,
  parameter int TAP_DDR1   = 32,
  parameter int TAP_DDR2   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            strap_ddr1,
  output logic [5:0]      cmd_pulse,
  output logic [MRW-1:0]  mode_val,
  output logic [MRW-1:0]  emode_val,
  output logic [14:0]     refresh_ctl,
  output logic [TAPW-1:0] dqs_tap0,
  output logic [TAPW-1:0] dqs_tap1,
  output logic            done
);
  localparam int CW = $clog2(LONG_WAIT + 1);
  localparam int SW = MRW + 4;
  localparam logic [2:0] OP_CMD = 3'd0, OP_MR = 3'd1, OP_EMR = 3'd2,
                         OP_REF = 3'd3, OP_TAP = 3'd4;
  localparam int C_MRS = 1, C_EMRS = 2, C_AREF = 4, C_PRE = 8, C_E2 = 16, C_E3 = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WAIT, ST_DONE} st_t;
  st_t st;
  logic          ddr1_q;
  logic [4:0]    idx;
  logic [CW-1:0] cnt;
  logic [SW-1:0] step;

  function automatic logic [SW-1:0] mk(input logic lw, input logic [2:0] op, input int a);
    return {lw, op, MRW'(a)};
  endfunction

  function automatic logic [SW-1:0] prog(input logic d1, input logic [4:0] i);
    logic [SW-1:0] s;
    s = mk(1'b1, OP_TAP, 0);
    if (d1) begin
      case (i)
        5'd0:  s = mk(1'b1, OP_CMD, C_PRE);
        5'd1:  s = mk(1'b1, OP_EMR, 'h000);
        5'd2:  s = mk(1'b1, OP_CMD, C_EMRS);
        5'd3:  s = mk(1'b1, OP_MR,  'h133);
        5'd4:  s = mk(1'b1, OP_CMD, C_MRS);
        5'd5:  s = mk(1'b1, OP_CMD, C_PRE);
        5'd6:  s = mk(1'b1, OP_CMD, C_AREF);
        5'd7:  s = mk(1'b1, OP_CMD, C_AREF);
        5'd8:  s = mk(1'b1, OP_MR,  'h033);
        5'd9:  s = mk(1'b1, OP_CMD, C_MRS);
        5'd10: s = mk(1'b1, OP_REF, 0);
        default: s = mk(1'b1, OP_TAP, 0);
      endcase
    end else begin
      case (i)
        5'd0:  s = mk(1'b0, OP_CMD, C_E2);
        5'd1:  s = mk(1'b0, OP_CMD, C_E3);
        5'd2:  s = mk(1'b1, OP_CMD, C_PRE);
        5'd3:  s = mk(1'b1, OP_CMD, C_E2);
        5'd4:  s = mk(1'b1, OP_CMD, C_E3);
        5'd5:  s = mk(1'b1, OP_EMR, 'h402);
        5'd6:  s = mk(1'b1, OP_CMD, C_EMRS);
        5'd7:  s = mk(1'b1, OP_MR,  'h143);
        5'd8:  s = mk(1'b1, OP_CMD, C_MRS);
        5'd9:  s = mk(1'b1, OP_CMD, C_PRE);
        5'd10: s = mk(1'b1, OP_CMD, C_AREF);
        5'd11: s = mk(1'b1, OP_CMD, C_AREF);
        5'd12: s = mk(1'b1, OP_MR,  'h043);
        5'd13: s = mk(1'b1, OP_CMD, C_MRS);
        5'd14: s = mk(1'b1, OP_EMR, 'h782);
        5'd15: s = mk(1'b1, OP_CMD, C_EMRS);
        5'd16: s = mk(1'b1, OP_EMR, 'h402);
        5'd17: s = mk(1'b1, OP_CMD, C_EMRS);
        5'd18: s = mk(1'b1, OP_REF, 0);
        default: s = mk(1'b1, OP_TAP, 0);
      endcase
    end
    return s;
  endfunction

  assign step = prog(ddr1_q, idx);

  wire           s_long = step[SW-1];
  wire [2:0]     s_op   = step[SW-2:MRW];
  wire [MRW-1:0] s_arg  = step[MRW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ddr1_q <= 1'b0; idx <= '0; cnt <= '0;
      cmd_pulse <= '0; mode_val <= '0; emode_val <= '0; refresh_ctl <= '0;
      dqs_tap0 <= '0; dqs_tap1 <= '0; done <= 1'b0;
    end else begin
      cmd_pulse <= '0;
      case (st)
        ST_IDLE: if (start) begin
          ddr1_q <= strap_ddr1;
          idx    <= '0;
          st     <= ST_EXEC;
        end
        ST_EXEC: begin
          case (s_op)
            OP_CMD: cmd_pulse   <= s_arg[5:0];
            OP_MR:  mode_val    <= s_arg;
            OP_EMR: emode_val   <= s_arg;
            OP_REF: refresh_ctl <= {1'b1, 4'b0, 10'(REF_PERIOD)};
            default: begin
              dqs_tap0 <= ddr1_q ? TAPW'(TAP_DDR1) : TAPW'(TAP_DDR2);
              dqs_tap1 <= ddr1_q ? TAPW'(TAP_DDR1) : TAPW'(TAP_DDR2);
              done     <= 1'b1;
            end
          endcase
          if (s_op == OP_TAP) st <= ST_DONE;
          else begin
            st  <= ST_WAIT;
            idx <= idx + 5'd1;
            cnt <= s_long ? CW'(LONG_WAIT - 1) : CW'(SHORT_WAIT - 1);
          end
        end
        ST_WAIT: if (cnt == '0) st <= ST_EXEC; else cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  assert_onehot_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse));
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |=> (cmd_pulse == '0));
  assert_values_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |-> ($stable(mode_val) && $stable(emode_val)));
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  assert_strap_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |=> $stable(ddr1_q));
  assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_pulse == '0));
endmodule

// File: tb/sim_dram_bringup_seq.sv
`timescale 1ns/1ps
module sim_dram_bringup_seq;
  localparam int S = 10, L = 100;
  localparam int REFV = 16'h4138;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, strap = 1'b0;
  logic [5:0]  cmd_pulse;
  logic [12:0] mode_val, emode_val;
  logic [14:0] refresh_ctl;
  logic [5:0]  dqs_tap0, dqs_tap1;
  logic        done;
  int vec = 0, err = 0;

  logic [12:0] e_mr, e_emr;
  logic [14:0] e_ref;
  logic [5:0]  e_tap;
  logic        e_done;

  always #2.5 clk = ~clk;

  dram_bringup_seq #(.SHORT_WAIT(S), .LONG_WAIT(L)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .strap_ddr1(strap),
    .cmd_pulse(cmd_pulse), .mode_val(mode_val), .emode_val(emode_val),
    .refresh_ctl(refresh_ctl), .dqs_tap0(dqs_tap0), .dqs_tap1(dqs_tap1), .done(done));

  // step format: {short_after, kind(0 cmd,1 mr,2 emr,3 ref,4 tap), value}
  function automatic logic [16:0] ex(bit d1, int i);
    if (d1) case (i)
      0: return {1'b0, 3'd0, 13'h008};  1: return {1'b0, 3'd2, 13'h000};
      2: return {1'b0, 3'd0, 13'h002};  3: return {1'b0, 3'd1, 13'h133};
      4: return {1'b0, 3'd0, 13'h001};  5: return {1'b0, 3'd0, 13'h008};
      6: return {1'b0, 3'd0, 13'h004};  7: return {1'b0, 3'd0, 13'h004};
      8: return {1'b0, 3'd1, 13'h033};  9: return {1'b0, 3'd0, 13'h001};
      10: return {1'b0, 3'd3, 13'h000}; default: return {1'b0, 3'd4, 13'h020};
    endcase
    case (i)
      0: return {1'b1, 3'd0, 13'h010};  1: return {1'b1, 3'd0, 13'h020};
      2: return {1'b0, 3'd0, 13'h008};  3: return {1'b0, 3'd0, 13'h010};
      4: return {1'b0, 3'd0, 13'h020};  5: return {1'b0, 3'd2, 13'h402};
      6: return {1'b0, 3'd0, 13'h002};  7: return {1'b0, 3'd1, 13'h143};
      8: return {1'b0, 3'd0, 13'h001};  9: return {1'b0, 3'd0, 13'h008};
      10: return {1'b0, 3'd0, 13'h004}; 11: return {1'b0, 3'd0, 13'h004};
      12: return {1'b0, 3'd1, 13'h043}; 13: return {1'b0, 3'd0, 13'h001};
      14: return {1'b0, 3'd2, 13'h782}; 15: return {1'b0, 3'd0, 13'h002};
      16: return {1'b0, 3'd2, 13'h402}; 17: return {1'b0, 3'd0, 13'h002};
      18: return {1'b0, 3'd3, 13'h000}; default: return {1'b0, 3'd4, 13'h010};
    endcase
  endfunction

  task automatic cmp(string r, logic [5:0] ec);
    logic [63:0] act, exp;
    act = {cmd_pulse, mode_val, emode_val, refresh_ctl, dqs_tap0, dqs_tap1, done};
    exp = {ec, e_mr, e_emr, e_ref, e_tap, e_tap, e_done};
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s: actual %h expected %h (cmd,mode,emode,ref,tap0,tap1,done)", r, act, exp);
    end
  endtask

  task automatic clr_exp();
    e_mr = '0; e_emr = '0; e_ref = '0; e_tap = '0; e_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clr_exp();
    cmp("R1 reset state", 6'd0);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      strap = 1'($urandom);
      cmp("R1 idle without start", 6'd0);
    end
  endtask

  task automatic run_seq(bit d1, bit noisy);
    int n, gap;
    logic [16:0] s, prev;
    n = d1 ? 12 : 20;
    strap = d1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev = '0;
    for (int i = 0; i < n; i++) begin
      s = ex(d1, i);
      gap = (i == 0) ? 1 : (prev[16] ? S + 1 : L + 1);
      for (int c = 0; c < gap - 1; c++) begin
        if (noisy) begin start = ($urandom % 4) == 0; strap = 1'($urandom); end
        @(negedge clk);
        cmp("R5 R9 R10 quiet between steps", 6'd0);
      end
      if (noisy) begin start = ($urandom % 4) == 0; strap = 1'($urandom); end
      @(negedge clk);
      case (s[15:13])
        3'd0: cmp(d1 ? "R3 R2 R6 command step" : "R4 R2 R6 command step", s[5:0]);
        3'd1: begin e_mr = s[12:0]; cmp(d1 ? "R3 mode load" : "R4 mode load", 6'd0); end
        3'd2: begin e_emr = s[12:0]; cmp(d1 ? "R3 ext load" : "R4 ext load", 6'd0); end
        3'd3: begin e_ref = 15'(REFV); cmp("R7 refresh load", 6'd0); end
        default: begin e_tap = d1 ? 6'h20 : 6'h10; e_done = 1'b1; cmp("R8 taps and done", 6'd0); end
      endcase
      prev = s;
    end
    for (int c = 0; c < 30; c++) begin
      start = (c % 3) == 0; strap = 1'($urandom);
      @(negedge clk);
      cmp("R8 R10 after done", 6'd0);
    end
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1f2e3d4c));
    clr_exp();
    @(negedge clk);
    do_reset(); run_seq(1'b1, 1'b0);
    do_reset(); run_seq(1'b0, 1'b0);
    do_reset(); run_seq(1'b1, 1'b1);
    do_reset(); run_seq(1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      do_reset(); run_seq(1'($urandom), 1'b1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule